// File: doc/BRIEF.md
# Memory Protection Region Checker

This block judges every bus access against a table of programmable protection regions and answers, in the same cycle, whether the access may proceed or must fault. Each region entry holds a base address, a power-of-two size, one permission field for privileged requests and one for unprivileged requests, an execute-never flag, a cacheable flag and a valid flag. Software fills an entry with a single write through the configuration port, and turns checking on or off with a separate control write.

With checking off, every access is judged against a fixed default address map. With checking on, the valid regions are searched, and the highest-numbered match supplies the attributes. An access that misses every region falls back to the default map if it is privileged and faults if it is not. The first fault is captured in a status record of address, cause and valid flag. A two-state machine holds that record until software clears it. Its states are FLT_EMPTY and FLT_HELD. The transition CAPTURE goes from FLT_EMPTY to FLT_HELD on a fault. The transition RELEASE goes from FLT_HELD to FLT_EMPTY when the clear input is high.

Top module: `mpr_checker`

## Requirements
- R1: `NUM_REGIONS` (at most 16) entries exist. A write with `cfg_wr` high stores all fields into entry `cfg_idx` at the next clock edge. A write whose index is `NUM_REGIONS` or above changes nothing. Only entries whose valid flag is 1 take part in matching.
- R2: A size code N covers 2^(N+1) bytes, and codes below 9 behave as 9 (1 KB). Base bits below the covered size are ignored, so an address matches when it agrees with the base in every bit at or above position N+1. N = 31 covers all 4 GB.
- R3: When several valid entries match, the attributes come from the highest-numbered one. `acc_region` gives that index when `acc_hit` is 1, and gives 0 otherwise.
- R4: A permission field has four codes. 2'b00 faults every access. 2'b01 allows reads only. 2'b10 allows writes only. 2'b11 allows both. Bit 0 grants read and bit 1 grants write.
- R5: Privileged requests (`req_priv`=1) use the entry's `ap_priv` field, and unprivileged requests use its `ap_user` field.
- R6: An instruction fetch (`req_fetch`=1, which takes precedence over `req_write`) needs read permission and a clear execute-never flag. Otherwise it faults.
- R7: `acc_cacheable` and `acc_xn` carry the flags of the winning entry, or the default-map flags when no entry supplies them.
- R8: After reset, checking is off, `prot_active` is 0 and `acc_hit` is 0. The default map uses address bits [31:29]. Code 0 is read-only, executable and cacheable. Code 1 is read/write, execute-never and cacheable. Every other code is read/write, execute-never and non-cacheable. Both privilege levels use this map.
- R9: While the record is empty, the first faulting access stores its address and a cause into `flt_addr` and `flt_cause`, and sets `flt_valid`. The cause codes are read 1, write 2 and fetch 3. Later faults leave the record unchanged while it is held.
- R10: `flt_clr` high while the record is held empties it at the next edge, even if a fault occurs in that same cycle. `flt_clr` has no effect on an empty record.
- R11: With checking on, an access that matches no valid entry faults if unprivileged and is judged by the default map if privileged.
- R12: `acc_allow`, `acc_fault`, `acc_hit`, `acc_region`, `acc_cacheable` and `acc_xn` are combinational in the request. `acc_fault` equals `req_valid` and not `acc_allow`. Both are 0 when `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Region entry write strobe |
| cfg_idx | input | 4 | Entry index to write |
| cfg_base | input | 32 | Region base address |
| cfg_size | input | 5 | Size code N, 2^(N+1) bytes |
| cfg_ap_priv | input | 2 | Permission for privileged requests |
| cfg_ap_user | input | 2 | Permission for unprivileged requests |
| cfg_xn | input | 1 | Execute-never flag |
| cfg_cache | input | 1 | Cacheable flag |
| cfg_valid | input | 1 | Entry valid flag |
| ctl_wr | input | 1 | Control write strobe |
| ctl_enable | input | 1 | Checking on (1) or default map only (0) |
| flt_clr | input | 1 | Clear the held fault record |
| req_valid | input | 1 | Access present |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_fetch | input | 1 | Instruction fetch |
| req_priv | input | 1 | Privileged request |
| acc_allow | output | 1 | Access permitted |
| acc_fault | output | 1 | Access violates protection |
| acc_cacheable | output | 1 | Merged cacheable attribute |
| acc_xn | output | 1 | Merged execute-never attribute |
| acc_hit | output | 1 | A valid entry matched with checking on |
| acc_region | output | 4 | Index of the winning entry |
| prot_active | output | 1 | Checking is on |
| flt_valid | output | 1 | Fault record held |
| flt_addr | output | 32 | Address of the captured fault |
| flt_cause | output | 2 | Cause of the captured fault |

## Verification
Some relations are checked on every cycle. A permitted fetch never comes from an execute-never area. With checking off, no entry ever reports a hit. An unprivileged miss with checking on always faults, and a default-map code write always faults while checking is off. The fault record is also checked for capture on the first fault, holding while set, and emptying on a clear. Other behaviour is shown only by the bench's address sweeps. These cover the exact region boundaries implied by each size code, the clamping of tiny sizes, the masking of unaligned bases, the winner among overlapping entries and the exclusion of invalid ones. The sweeps also show that an out-of-range entry write is ignored and that the cause code matches each kind of access.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    localparam int MAX_REGIONS = 16;
    localparam int IDX_W       = 4;
    localparam int ADDR_W      = 32;
    localparam int SIZE_W      = 5;

    localparam logic [SIZE_W-1:0] SIZE_FLOOR = 5'd9;

    localparam logic [1:0] AP_NONE = 2'b00;
    localparam logic [1:0] AP_RO   = 2'b01;
    localparam logic [1:0] AP_WO   = 2'b10;
    localparam logic [1:0] AP_RW   = 2'b11;

    localparam logic [1:0] CAUSE_READ  = 2'd1;
    localparam logic [1:0] CAUSE_WRITE = 2'd2;
    localparam logic [1:0] CAUSE_FETCH = 2'd3;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [SIZE_W-1:0] size;
        logic [1:0]        ap_priv;
        logic [1:0]        ap_user;
        logic              xn;
        logic              cache;
        logic              valid;
    } region_t;

    typedef struct packed {
        logic [1:0] ap;
        logic       xn;
        logic       cache;
    } attr_t;

    // Fixed map used when checking is off or a privileged access misses.
    function automatic attr_t default_attr(input logic [2:0] top);
        attr_t a;
        case (top)
            3'd0:    a = '{ap: AP_RO, xn: 1'b0, cache: 1'b1};
            3'd1:    a = '{ap: AP_RW, xn: 1'b1, cache: 1'b1};
            default: a = '{ap: AP_RW, xn: 1'b1, cache: 1'b0};
        endcase
        return a;
    endfunction

endpackage

// File: rtl/mpr_region_file.sv
module mpr_region_file
    import mpr_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_wr,
    input  logic [IDX_W-1:0]              cfg_idx,
    input  region_t                       cfg_entry,
    input  logic                          ctl_wr,
    input  logic                          ctl_enable,
    output region_t [NUM_REGIONS-1:0]     regs,
    output logic                          enabled
);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_entry
        localparam logic [IDX_W-1:0] MY_IDX = g[IDX_W-1:0];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (cfg_wr && cfg_idx == MY_IDX) begin
                regs[g] <= cfg_entry;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enabled <= 1'b0;
        end else if (ctl_wr) begin
            enabled <= ctl_enable;
        end
    end

endmodule

// File: rtl/mpr_lookup.sv
module mpr_lookup
    import mpr_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  region_t [NUM_REGIONS-1:0] regs,
    input  logic                      enabled,
    input  logic                      req_valid,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic                      req_write,
    input  logic                      req_fetch,
    input  logic                      req_priv,
    output logic                      acc_allow,
    output logic                      acc_fault,
    output logic                      acc_cacheable,
    output logic                      acc_xn,
    output logic                      acc_hit,
    output logic [IDX_W-1:0]          acc_region,
    output logic [1:0]                acc_cause
);

    logic [NUM_REGIONS-1:0] hit_vec;
    logic                   any_hit;
    logic [IDX_W-1:0]       win;
    region_t                win_reg;
    attr_t                  dflt;
    logic [1:0]             ap_sel;
    logic                   xn_sel;
    logic                   cache_sel;

    // Per-entry address compare with size clamping and base masking.
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
        logic [SIZE_W-1:0] eff_size;
        logic [5:0]        span_log2;
        logic [ADDR_W:0]   low_mask;
        always_comb begin
            eff_size  = (regs[g].size < SIZE_FLOOR) ? SIZE_FLOOR : regs[g].size;
            span_log2 = {1'b0, eff_size} + 6'd1;
            low_mask  = ({{ADDR_W{1'b0}}, 1'b1} << span_log2) - {{ADDR_W{1'b0}}, 1'b1};
            hit_vec[g] = regs[g].valid &&
                         (((req_addr ^ regs[g].base) & ~low_mask[ADDR_W-1:0]) == '0);
        end
    end

    // Highest-numbered match wins: later iterations overwrite earlier ones.
    always_comb begin
        any_hit = 1'b0;
        win     = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                win     = i[IDX_W-1:0];
            end
        end
    end

    assign win_reg = regs[win];
    assign dflt    = default_attr(req_addr[ADDR_W-1:ADDR_W-3]);

    always_comb begin
        ap_sel    = dflt.ap;
        xn_sel    = dflt.xn;
        cache_sel = dflt.cache;
        if (enabled) begin
            if (any_hit) begin
                ap_sel    = req_priv ? win_reg.ap_priv : win_reg.ap_user;
                xn_sel    = win_reg.xn;
                cache_sel = win_reg.cache;
            end else if (!req_priv) begin
                ap_sel = AP_NONE;
            end
        end
    end

    logic permit;
    always_comb begin
        if (req_fetch) begin
            permit = ap_sel[0] && !xn_sel;
        end else if (req_write) begin
            permit = ap_sel[1];
        end else begin
            permit = ap_sel[0];
        end
    end

    assign acc_allow     = req_valid && permit;
    assign acc_fault     = req_valid && !permit;
    assign acc_cacheable = cache_sel;
    assign acc_xn        = xn_sel;
    assign acc_hit       = enabled && any_hit;
    assign acc_region    = (enabled && any_hit) ? win : '0;
    assign acc_cause     = req_fetch ? CAUSE_FETCH : (req_write ? CAUSE_WRITE : CAUSE_READ);

endmodule

// File: rtl/mpr_fault_fsm.sv
module mpr_fault_fsm
    import mpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault,
    input  logic [1:0]        cause,
    input  logic [ADDR_W-1:0] addr,
    input  logic              clr,
    output logic              flt_valid,
    output logic [ADDR_W-1:0] flt_addr,
    output logic [1:0]        flt_cause
);

    typedef enum logic [0:0] {FLT_EMPTY = 1'b0, FLT_HELD = 1'b1} flt_state_t;

    flt_state_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FLT_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            FLT_EMPTY: if (fault) state_nxt = FLT_HELD;   // CAPTURE
            FLT_HELD:  if (clr)   state_nxt = FLT_EMPTY;  // RELEASE
            default:   state_nxt = FLT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_addr  <= '0;
            flt_cause <= '0;
        end else if (state == FLT_EMPTY && fault) begin
            flt_addr  <= addr;
            flt_cause <= cause;
        end
    end

    assign flt_valid = (state == FLT_HELD);

endmodule

// File: rtl/mpr_checker.sv
module mpr_checker
    import mpr_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [3:0]  cfg_idx,
    input  logic [31:0] cfg_base,
    input  logic [4:0]  cfg_size,
    input  logic [1:0]  cfg_ap_priv,
    input  logic [1:0]  cfg_ap_user,
    input  logic        cfg_xn,
    input  logic        cfg_cache,
    input  logic        cfg_valid,
    input  logic        ctl_wr,
    input  logic        ctl_enable,
    input  logic        flt_clr,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic        req_write,
    input  logic        req_fetch,
    input  logic        req_priv,
    output logic        acc_allow,
    output logic        acc_fault,
    output logic        acc_cacheable,
    output logic        acc_xn,
    output logic        acc_hit,
    output logic [3:0]  acc_region,
    output logic        prot_active,
    output logic        flt_valid,
    output logic [31:0] flt_addr,
    output logic [1:0]  flt_cause
);

    region_t                   cfg_entry;
    region_t [NUM_REGIONS-1:0] regs;
    logic [1:0]                cause;

    assign cfg_entry = '{base: cfg_base, size: cfg_size, ap_priv: cfg_ap_priv,
                         ap_user: cfg_ap_user, xn: cfg_xn, cache: cfg_cache,
                         valid: cfg_valid};

    mpr_region_file #(.NUM_REGIONS(NUM_REGIONS)) u_file (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_idx    (cfg_idx),
        .cfg_entry  (cfg_entry),
        .ctl_wr     (ctl_wr),
        .ctl_enable (ctl_enable),
        .regs       (regs),
        .enabled    (prot_active)
    );

    mpr_lookup #(.NUM_REGIONS(NUM_REGIONS)) u_lookup (
        .regs          (regs),
        .enabled       (prot_active),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_write     (req_write),
        .req_fetch     (req_fetch),
        .req_priv      (req_priv),
        .acc_allow     (acc_allow),
        .acc_fault     (acc_fault),
        .acc_cacheable (acc_cacheable),
        .acc_xn        (acc_xn),
        .acc_hit       (acc_hit),
        .acc_region    (acc_region),
        .acc_cause     (cause)
    );

    mpr_fault_fsm u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault     (acc_fault),
        .cause     (cause),
        .addr      (req_addr),
        .clr       (flt_clr),
        .flt_valid (flt_valid),
        .flt_addr  (flt_addr),
        .flt_cause (flt_cause)
    );

endmodule

// File: rtl/mpr_checker_sva.sv
module mpr_checker_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        flt_clr,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        req_write,
    input logic        req_fetch,
    input logic        req_priv,
    input logic        acc_allow,
    input logic        acc_fault,
    input logic        acc_xn,
    input logic        acc_hit,
    input logic        prot_active,
    input logic        flt_valid,
    input logic [31:0] flt_addr
);

    AST_FETCH_NOT_XN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_fetch && acc_allow |-> !acc_xn); // R6

    AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_active |-> !acc_hit); // R8

    AST_OFF_CODE_RO: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_active && req_valid && req_write && !req_fetch && req_addr[31:29] == 3'd0
        |-> acc_fault); // R8

    AST_USER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        prot_active && req_valid && !req_priv && !acc_hit |-> acc_fault); // R11

    AST_FLT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_valid && acc_fault |=> flt_valid && flt_addr == $past(req_addr)); // R9

    AST_FLT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && !flt_clr |=> flt_valid && $stable(flt_addr)); // R9

    AST_FLT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && flt_clr |=> !flt_valid); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !acc_allow && !acc_fault); // R12

endmodule

bind mpr_checker mpr_checker_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .flt_clr     (flt_clr),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_write   (req_write),
    .req_fetch   (req_fetch),
    .req_priv    (req_priv),
    .acc_allow   (acc_allow),
    .acc_fault   (acc_fault),
    .acc_xn      (acc_xn),
    .acc_hit     (acc_hit),
    .prot_active (prot_active),
    .flt_valid   (flt_valid),
    .flt_addr    (flt_addr)
);

// File: tb/sim_mpr_checker.sv
`timescale 1ns/1ps
module sim_mpr_checker;

    localparam int NR = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0;
    logic [4:0]  cfg_size = '0;
    logic [1:0]  cfg_ap_priv = '0;
    logic [1:0]  cfg_ap_user = '0;
    logic        cfg_xn = 1'b0;
    logic        cfg_cache = 1'b0;
    logic        cfg_valid = 1'b0;
    logic        ctl_wr = 1'b0;
    logic        ctl_enable = 1'b0;
    logic        flt_clr = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_fetch = 1'b0;
    logic        req_priv = 1'b0;
    logic        acc_allow, acc_fault, acc_cacheable, acc_xn, acc_hit;
    logic [3:0]  acc_region;
    logic        prot_active, flt_valid;
    logic [31:0] flt_addr;
    logic [1:0]  flt_cause;

    always #10 clk = ~clk;

    mpr_checker #(.NUM_REGIONS(NR)) u0 (.*);

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Bench-side shadow of the region table
    logic [31:0] m_base [NR];
    logic [4:0]  m_size [NR];
    logic [1:0]  m_app  [NR];
    logic [1:0]  m_apu  [NR];
    logic        m_xn   [NR];
    logic        m_c    [NR];
    logic        m_v    [NR];
    logic        m_en = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    function automatic bit covers(input int i, input logic [31:0] a);
        int sh;
        logic [63:0] x, y;
        sh = (m_size[i] < 5'd9) ? 10 : int'(m_size[i]) + 1;
        x  = {32'h0, a} >> sh;
        y  = {32'h0, m_base[i]} >> sh;
        return x == y;
    endfunction

    // returns {allow, cache, hit, xn, region[3:0]}
    function automatic logic [7:0] model(input logic [31:0] a, input int op, input bit priv);
        logic [1:0] ap;
        logic xn, c, hit;
        logic [3:0] rg;
        bit allow;
        case (a[31:29])
            3'd0:    begin ap = 2'b01; xn = 1'b0; c = 1'b1; end
            3'd1:    begin ap = 2'b11; xn = 1'b1; c = 1'b1; end
            default: begin ap = 2'b11; xn = 1'b1; c = 1'b0; end
        endcase
        hit = 1'b0;
        rg  = 4'd0;
        if (m_en) begin
            for (int i = 0; i < NR; i++) begin
                if (m_v[i] && covers(i, a)) begin
                    hit = 1'b1;
                    rg  = 4'(i);
                end
            end
            if (hit) begin
                ap = priv ? m_app[rg] : m_apu[rg];
                xn = m_xn[rg];
                c  = m_c[rg];
            end else if (!priv) begin
                ap = 2'b00;
            end
        end
        if (op == 2)      allow = ap[0] && !xn;
        else if (op == 1) allow = ap[1];
        else              allow = ap[0];
        return {allow, c, hit, xn, rg};
    endfunction

    task automatic prog(input int idx, input logic [31:0] b, input logic [4:0] s,
                        input logic [1:0] app, input logic [1:0] apu,
                        input logic xn, input logic c, input logic v);
        cfg_wr = 1'b1; cfg_idx = 4'(idx); cfg_base = b; cfg_size = s;
        cfg_ap_priv = app; cfg_ap_user = apu; cfg_xn = xn; cfg_cache = c; cfg_valid = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (idx < NR) begin
            m_base[idx] = b; m_size[idx] = s; m_app[idx] = app; m_apu[idx] = apu;
            m_xn[idx] = xn; m_c[idx] = c; m_v[idx] = v;
        end
    endtask

    task automatic set_enable(input logic e);
        ctl_wr = 1'b1; ctl_enable = e;
        @(negedge clk);
        ctl_wr = 1'b0;
        m_en = e;
    endtask

    // Drives a request right after a falling edge, checks combinationally, returns at next falling edge.
    task automatic probe(input logic [31:0] a, input int op, input bit priv, input string req);
        logic [7:0] e;
        req_valid = 1'b1; req_addr = a; req_write = (op == 1); req_fetch = (op == 2); req_priv = priv;
        #2;
        e = model(a, op, priv);
        check(req, "allow (R12)", 32'(acc_allow), 32'(e[7]));
        check(req, "fault (R4)", 32'(acc_fault), 32'(!e[7]));
        check(req, "cacheable (R7)", 32'(acc_cacheable), 32'(e[6]));
        check(req, "hit (R3)", 32'(acc_hit), 32'(e[5]));
        check(req, "xn (R6)", 32'(acc_xn), 32'(e[4]));
        check(req, "region (R3)", 32'(acc_region), 32'(e[3:0]));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    logic [31:0] addrs [16] = '{32'h0000_0000, 32'h0008_0000, 32'h0000_8010, 32'h0000_8400,
                                32'h0010_0000, 32'h2000_0000, 32'h2000_0410, 32'h2000_0810,
                                32'h2001_0000, 32'h4000_0000, 32'h4000_0FFC, 32'h4000_1000,
                                32'h6000_0FFF, 32'h7000_03FC, 32'h7000_0400, 32'hFFFF_FFFC};

    task automatic sweep(input string req);
        for (int ai = 0; ai < 16; ai++)
            for (int op = 0; op < 3; op++)
                for (int p = 0; p < 2; p++)
                    probe(addrs[ai], op, p[0], req);
    endtask

    task automatic fault_pulse(input logic [31:0] a, input int op, input bit priv, input bit clr);
        req_valid = 1'b1; req_addr = a; req_write = (op == 1); req_fetch = (op == 2);
        req_priv = priv; flt_clr = clr;
        @(negedge clk);
        req_valid = 1'b0; flt_clr = 1'b0;
        #2;
    endtask

    task automatic summary;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20.0 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) begin
            m_base[i] = '0; m_size[i] = '0; m_app[i] = '0; m_apu[i] = '0;
            m_xn[i] = 1'b0; m_c[i] = 1'b0; m_v[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R8, R9, R12)
        check("R8", "prot_active after reset", 32'(prot_active), 32'd0);
        check("R9", "flt_valid after reset", 32'(flt_valid), 32'd0);
        check("R12", "allow idle", 32'(acc_allow), 32'd0);
        check("R12", "fault idle", 32'(acc_fault), 32'd0);
        check("R8", "hit after reset", 32'(acc_hit), 32'd0);

        // Program the table while checking is off
        prog(0, 32'h0000_0000, 5'd19, 2'b01, 2'b01, 1'b0, 1'b1, 1'b1); // 1 MB code
        prog(1, 32'h2000_0000, 5'd15, 2'b11, 2'b11, 1'b1, 1'b1, 1'b1); // 64 KB data
        prog(2, 32'h2000_0400, 5'd9,  2'b11, 2'b00, 1'b1, 1'b0, 1'b1); // overlap, priv-only
        prog(3, 32'h4000_1234, 5'd11, 2'b11, 2'b01, 1'b1, 1'b0, 1'b1); // unaligned base (R2)
        prog(4, 32'h6000_0000, 5'd11, 2'b10, 2'b10, 1'b0, 1'b0, 1'b1); // write-only
        prog(5, 32'h2000_0800, 5'd9,  2'b00, 2'b00, 1'b1, 1'b0, 1'b0); // invalid (R1)
        prog(6, 32'h7000_0000, 5'd2,  2'b11, 2'b11, 1'b0, 1'b1, 1'b1); // clamped to 1 KB (R2)
        prog(7, 32'h0000_8000, 5'd9,  2'b00, 2'b00, 1'b0, 1'b0, 1'b1); // overrides entry 0 (R3)
        prog(12, 32'h0000_0000, 5'd31, 2'b11, 2'b11, 1'b0, 1'b1, 1'b1); // out of range (R1)

        // R8: checking off, default map for both privilege levels
        sweep("R8");

        set_enable(1'b1);
        check("R8", "prot_active after enable", 32'(prot_active), 32'd1);

        // R1 R2 R3 R4 R5 R6 R7 R11: enabled sweep
        sweep("R3");

        // R1: out-of-range write left no all-covering entry, unprivileged miss faults
        probe(32'h2001_0000, 0, 1'b0, "R1");

        // Fault record sequence
        fault_pulse(32'h0, 0, 1'b1, 1'b1);           // clear any held record
        check("R10", "flt_valid after clear", 32'(flt_valid), 32'd0);

        fault_pulse(32'hABCD_0000, 0, 1'b0, 1'b0);   // unpriv miss read -> fault A
        check("R9", "flt_valid captured", 32'(flt_valid), 32'd1);
        check("R9", "flt_addr captured", flt_addr, 32'hABCD_0000);
        check("R9", "flt_cause read", 32'(flt_cause), 32'd1);

        fault_pulse(32'h0008_0000, 1, 1'b1, 1'b0);   // write to read-only, must not replace
        check("R9", "flt_addr held", flt_addr, 32'hABCD_0000);
        check("R9", "flt_cause held", 32'(flt_cause), 32'd1);

        fault_pulse(32'h0008_0004, 1, 1'b1, 1'b1);   // clear wins over simultaneous fault
        check("R10", "clear beats new fault", 32'(flt_valid), 32'd0);

        fault_pulse(32'h2000_0000, 2, 1'b1, 1'b0);   // fetch from execute-never
        check("R6", "fetch fault captured", 32'(flt_valid), 32'd1);
        check("R9", "flt_cause fetch", 32'(flt_cause), 32'd3);
        check("R9", "flt_addr fetch", flt_addr, 32'h2000_0000);

        fault_pulse(32'h0, 0, 1'b1, 1'b1);
        fault_pulse(32'h6000_0010, 0, 1'b1, 1'b1);   // clear on empty record is ignored: capture read of write-only
        check("R10", "clear ignored when empty", 32'(flt_valid), 32'd1);
        check("R9", "flt_cause read of write-only", 32'(flt_cause), 32'd1);

        fault_pulse(32'h0, 0, 1'b1, 1'b1);
        fault_pulse(32'h0000_8000, 1, 1'b1, 1'b0);   // write into no-access entry 7
        check("R9", "flt_cause write", 32'(flt_cause), 32'd2);
        check("R9", "flt_addr write", flt_addr, 32'h0000_8000);

        // Disable again: default map returns (R8)
        set_enable(1'b0);
        probe(32'h2000_0410, 0, 1'b0, "R8");

        finished = 1'b1;
        summary();
    end

endmodule